// File: doc/BRIEF.md
# Key-Locked Flash Control Register

This block is the control register of an embedded flash controller. It holds the program enable, three erase request bits (sector, bank, whole array), a 7-bit sector number, a bank select, an erase start bit and five interrupt enables. All of these fields are guarded by a lock. The lock is set out of reset. It opens only after two fixed keys are written, in order, to a separate key address.

A plain register bus reaches the block through a write strobe, a word address and 32-bit write data, with combinational read data. Toward the flash array, the block gives a one-cycle launch pulse together with the operation kind, the sector and the bank. It receives a completion pulse and three error pulses. When the start bit is written, the block checks that exactly one erase request is set. If the check fails, it raises a sequence error instead of launching. Event flags sit at a status address and are cleared by writing 1 to them. The interrupt line is the OR of every flag whose enable is set.

The bus has no back-pressure: every write is taken in the cycle its strobe is high.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset, the control word (address 1) reads 0x8000_0000 with only the lock bit (bit 31) set. The status word (address 2) reads 0, and irq_o, op_start_o and pgm_en_o are 0.
- R2: While the lock bit is 1, a write to the control word changes no field. Control word layout: bit0 program enable, bit1 sector erase, bit2 bank erase, bit3 whole-array erase, bit4 start, bits 11:5 sector number, bit12 bank select, bits 20:16 interrupt enables, bit31 lock.
- R3: Writing 0x4D2A_91C3 and then 0x0B7E_E56F to the key address (address 0) clears the lock. Any other pair of key writes does not clear it. Writes to other addresses between the two key writes do not break the sequence.
- R4: A wrong key value, or any key write while unlocked, leaves the lock at 1 until reset. After that, a correct sequence no longer unlocks it.
- R5: Writing the control word with bit31 = 1 while unlocked sets the lock and leaves every other field unchanged. A fresh key sequence then unlocks it again.
- R6: A start write with exactly one erase request raises op_start_o for one cycle, in the cycle after the write. In that cycle op_kind_o is 0 for sector, 1 for bank or 2 for whole-array erase, and op_sector_o and op_bank_o give the stored fields.
- R7: The start bit reads 1 from the write until op_done_i or an error pulse ends the operation. A software write of 0 to it has no effect.
- R8: A start write with zero or several erase requests sets status bit 2 (sequence error). If status bit 2 is already set, a start write also fails. A failed start launches nothing, and the start bit reads 0 one cycle after the write.
- R9: Status bits are: 0 end of operation (op_done_i during a launched operation), 1 protection error, 2 sequence error, 3 strobe error and 4 inconsistency error. Writing 1 to a status bit clears it. irq_o is 1 exactly when some status bit i and enable bit 16+i are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address (0 key, 1 control, 2 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pgm_en_o | output | 1 | Program enable field |
| op_start_o | output | 1 | One-cycle erase launch pulse |
| op_kind_o | output | 2 | Erase kind: 0 sector, 1 bank, 2 whole array |
| op_sector_o | output | SECT_W | Target sector |
| op_bank_o | output | 1 | Target bank (0 first, 1 second) |
| op_done_i | input | 1 | Operation completed pulse |
| op_prot_err_i | input | 1 | Protection error pulse |
| op_strb_err_i | input | 1 | Strobe error pulse |
| op_inc_err_i | input | 1 | Inconsistency error pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted lock state shows at once on bit 31 of the control word. It also shows one cycle after a control write, because the fields either change when they should not or stay when they should change. A wrong start-bit state shows in the launch timing: the pulse comes one cycle late or early, comes twice, comes after a conflicting request, or the start bit stays at 1 after completion. A wrong flag or enable shows on irq_o in the same cycle as the enable write. The sweeps step through every sector, every request combination and every enable mask against each remaining flag set, so a stuck bit is caught within a few cycles of its use.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int SECT_W = 7;
  localparam int NFLAG  = 5;

  // control word bit positions
  localparam int B_PG    = 0;
  localparam int B_SER   = 1;
  localparam int B_BER   = 2;
  localparam int B_MER   = 3;
  localparam int B_START = 4;
  localparam int B_SECT  = 5;
  localparam int B_BANK  = B_SECT + SECT_W;
  localparam int B_IE    = 16;
  localparam int B_LOCK  = 31;

  // status flag indices
  localparam int F_EOP  = 0;
  localparam int F_PROT = 1;
  localparam int F_SEQ  = 2;
  localparam int F_STRB = 3;
  localparam int F_INC  = 4;

  typedef enum logic [1:0] {
    OP_SECTOR = 2'd0,
    OP_BANK   = 2'd1,
    OP_MASS   = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic              pgm_en;
    logic              ser;
    logic              ber;
    logic              mer;
    logic [SECT_W-1:0] sector;
    logic              bank;
    logic [NFLAG-1:0]  ie;
  } ctrl_fields_t;
endpackage

// File: rtl/flash_key_lock.sv
module flash_key_lock #(
  parameter logic [31:0] KEY_A = 32'h4D2A_91C3,
  parameter logic [31:0] KEY_B = 32'h0B7E_E56F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock_req,
  output logic        locked_o
);
  typedef enum logic [1:0] {S_WAIT_A, S_WAIT_B, S_OPEN, S_DEAD} kst_e;
  kst_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_WAIT_A;
    end else begin
      unique case (st_q)
        S_WAIT_A: if (key_wr) st_q <= (key_data == KEY_A) ? S_WAIT_B : S_DEAD;
        S_WAIT_B: if (key_wr) st_q <= (key_data == KEY_B) ? S_OPEN : S_DEAD;
        S_OPEN: begin
          if (key_wr)          st_q <= S_DEAD;
          else if (relock_req) st_q <= S_WAIT_A;
        end
        default: st_q <= S_DEAD;
      endcase
    end
  end

  assign locked_o = (st_q != S_OPEN);

  // R3: the lock opens only on the second key write carrying the second key
  p_unlock_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(key_wr && key_data == KEY_B));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_set_i,
  input  logic start_bad_i,
  input  logic seq_flag_i,
  input  logic op_done_i,
  input  logic op_fail_i,
  output logic start_o,
  output logic busy_o,
  output logic op_start_o,
  output logic seq_set_o
);
  logic start_q, launched_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      launched_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (!start_q) begin
        if (start_set_i) start_q <= 1'b1;
      end else if (!launched_q) begin
        if (seq_flag_i) begin
          start_q <= 1'b0;
        end else begin
          pulse_q    <= 1'b1;
          launched_q <= 1'b1;
        end
      end else if (op_done_i || op_fail_i) begin
        start_q    <= 1'b0;
        launched_q <= 1'b0;
      end
    end
  end

  assign seq_set_o  = start_set_i && !start_q && start_bad_i;
  assign start_o    = start_q;
  assign busy_o     = launched_q;
  assign op_start_o = pulse_q;

  // R8: a pending start facing a sequence error is dropped without launch
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !launched_q && seq_flag_i) |=> (!start_q && !pulse_q));
  // R7: a launched start survives until done or error
  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launched_q && !op_done_i && !op_fail_i) |=> start_q);
  // R6: launch is a single-cycle pulse
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/flash_irq_flags.sv
module flash_irq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  // R9: a write-one clear with no competing event empties the cleared bits
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0 && set_i == '0) |=> ((flags_q & $past(clr_i)) == '0));
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
#(
  parameter int              ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_KEY  = 0,
  parameter logic [ADDR_W-1:0] A_CTRL = 1,
  parameter logic [ADDR_W-1:0] A_STAT = 2,
  parameter logic [31:0]     KEY_A  = 32'h4D2A_91C3,
  parameter logic [31:0]     KEY_B  = 32'h0B7E_E56F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pgm_en_o,
  output logic              op_start_o,
  output logic [1:0]        op_kind_o,
  output logic [SECT_W-1:0] op_sector_o,
  output logic              op_bank_o,
  input  logic              op_done_i,
  input  logic              op_prot_err_i,
  input  logic              op_strb_err_i,
  input  logic              op_inc_err_i,
  output logic              irq_o
);
  logic locked, key_wr, ctrl_wr, stat_wr, relock, field_wr;
  logic start_set, start_bad, start_q, busy, seq_set;
  logic [2:0] req_new;
  logic [NFLAG-1:0] flag_set, flag_clr, flags;
  ctrl_fields_t ctrl_q;
  op_kind_e kind;

  assign key_wr   = bus_wr && (bus_addr == A_KEY);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL) && !locked;
  assign stat_wr  = bus_wr && (bus_addr == A_STAT);
  assign relock   = ctrl_wr && bus_wdata[B_LOCK];
  assign field_wr = ctrl_wr && !bus_wdata[B_LOCK];

  flash_key_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
    .relock_req(relock), .locked_o(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (field_wr) begin
      ctrl_q.pgm_en <= bus_wdata[B_PG];
      ctrl_q.ser    <= bus_wdata[B_SER];
      ctrl_q.ber    <= bus_wdata[B_BER];
      ctrl_q.mer    <= bus_wdata[B_MER];
      ctrl_q.sector <= bus_wdata[B_SECT +: SECT_W];
      ctrl_q.bank   <= bus_wdata[B_BANK];
      ctrl_q.ie     <= bus_wdata[B_IE +: NFLAG];
    end
  end

  assign req_new   = {bus_wdata[B_MER], bus_wdata[B_BER], bus_wdata[B_SER]};
  assign start_set = field_wr && bus_wdata[B_START];
  assign start_bad = ($countones(req_new) != 1);

  flash_erase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_set_i(start_set), .start_bad_i(start_bad),
    .seq_flag_i(flags[F_SEQ]), .op_done_i(op_done_i),
    .op_fail_i(op_prot_err_i || op_strb_err_i || op_inc_err_i),
    .start_o(start_q), .busy_o(busy), .op_start_o(op_start_o), .seq_set_o(seq_set)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_EOP]  = op_done_i && busy;
    flag_set[F_PROT] = op_prot_err_i;
    flag_set[F_SEQ]  = seq_set;
    flag_set[F_STRB] = op_strb_err_i;
    flag_set[F_INC]  = op_inc_err_i;
  end
  assign flag_clr = stat_wr ? bus_wdata[NFLAG-1:0] : '0;

  flash_irq_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr),
    .en_i(ctrl_q.ie), .flags_o(flags), .irq_o(irq_o)
  );

  always_comb begin
    if (ctrl_q.mer)      kind = OP_MASS;
    else if (ctrl_q.ber) kind = OP_BANK;
    else                 kind = OP_SECTOR;
  end

  assign op_kind_o   = kind;
  assign op_sector_o = ctrl_q.sector;
  assign op_bank_o   = ctrl_q.bank;
  assign pgm_en_o    = ctrl_q.pgm_en;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[B_PG]               = ctrl_q.pgm_en;
      bus_rdata[B_SER]              = ctrl_q.ser;
      bus_rdata[B_BER]              = ctrl_q.ber;
      bus_rdata[B_MER]              = ctrl_q.mer;
      bus_rdata[B_START]            = start_q;
      bus_rdata[B_SECT +: SECT_W]   = ctrl_q.sector;
      bus_rdata[B_BANK]             = ctrl_q.bank;
      bus_rdata[B_IE +: NFLAG]      = ctrl_q.ie;
      bus_rdata[B_LOCK]             = locked;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[NFLAG-1:0] = flags;
    end
  end

  // R2: a control write while locked leaves every field as it was
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && locked) |=> $stable(ctrl_q));
  // R4: a key write while open closes the lock
  p_rekey_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !locked) |=> locked);
  // R9: an enabled completion raises the interrupt next cycle
  p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done_i && busy && ctrl_q.ie[F_EOP]) |=> irq_o);
endmodule

// File: tb/flash_ctl_reg_tb.sv
module flash_ctl_reg_tb_top;
  localparam logic [31:0] KA = 32'h4D2A_91C3;
  localparam logic [31:0] KB = 32'h0B7E_E56F;
  localparam logic [3:0] AK = 4'd0, AC = 4'd1, AS = 4'd2;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pgm_en_o, op_start_o, op_bank_o, irq_o;
  logic [1:0] op_kind_o;
  logic [6:0] op_sector_o;
  logic op_done_i = 0, op_prot_err_i = 0, op_strb_err_i = 0, op_inc_err_i = 0;
  int n_tot = 0, n_bad = 0;

  always #10 clk = ~clk;

  flash_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pgm_en_o(pgm_en_o),
    .op_start_o(op_start_o), .op_kind_o(op_kind_o), .op_sector_o(op_sector_o),
    .op_bank_o(op_bank_o), .op_done_i(op_done_i), .op_prot_err_i(op_prot_err_i),
    .op_strb_err_i(op_strb_err_i), .op_inc_err_i(op_inc_err_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] cw(input logic pg, ser, ber, mer, st,
                                     input logic [6:0] sec, input logic bk,
                                     input logic [4:0] ie, input logic lk);
    return {lk, 10'd0, ie, 3'd0, bk, sec, st, mer, ber, ser, pg};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(AK, KA);
    wr(AK, KB);
  endtask

  // start an erase with one request, check the launch, then complete it
  task automatic launch_ok(input logic ser, ber, mer, input logic [6:0] sec,
                           input logic bk, input logic [1:0] kind);
    logic [31:0] v;
    wr(AC, cw(1'b0, ser, ber, mer, 1'b1, sec, bk, 5'd0, 1'b0));
    chk("R6 no pulse in write cycle", {31'd0, op_start_o}, 32'd0);
    @(negedge clk);
    chk("R6 pulse", {31'd0, op_start_o}, 32'd1);
    chk("R6 kind", {30'd0, op_kind_o}, {30'd0, kind});
    chk("R6 sector", {25'd0, op_sector_o}, {25'd0, sec});
    chk("R6 bank", {31'd0, op_bank_o}, {31'd0, bk});
    op_done_i = 1'b1;
    @(negedge clk);
    op_done_i = 1'b0;
    chk("R6 pulse ends", {31'd0, op_start_o}, 32'd0);
    rd(AC, v);
    chk("R7 start cleared by done", {31'd0, v[4]}, 32'd0);
    rd(AS, v);
    chk("R9 end flag", v, 32'd1);
    wr(AS, 32'h1F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    do_reset();

    // R1 reset state
    rd(AC, v); chk("R1 control", v, 32'h8000_0000);
    rd(AS, v); chk("R1 status", v, 32'd0);
    chk("R1 outputs", {29'd0, irq_o, op_start_o, pgm_en_o}, 32'd0);

    // R2 locked writes ignored
    wr(AC, 32'h7FFF_FFEF);
    rd(AC, v); chk("R2 locked write", v, 32'h8000_0000);
    chk("R2 pgm_en", {31'd0, pgm_en_o}, 32'd0);

    // R3 key pair sweep
    for (int c = 0; c < 5; c++) begin
      do_reset();
      case (c)
        0: begin wr(AK, KA); wr(AK, KB); end
        1: begin wr(AK, KB); wr(AK, KA); end
        2: begin wr(AK, KA); wr(AK, KA); end
        3: begin wr(AK, KA ^ 32'h1); wr(AK, KB); end
        default: begin wr(AK, KA); wr(AC, 32'h1); wr(AS, 32'h1F); wr(AK, KB); end
      endcase
      rd(AC, v);
      chk("R3 unlock pair", {31'd0, v[31]}, {31'd0, !(c == 0 || c == 4)});
    end
    wr(AC, cw(1'b1, 0, 0, 0, 0, 7'd0, 0, 5'd0, 0));
    chk("R2 pgm_en unlocked", {31'd0, pgm_en_o}, 32'd1);

    // R4 rekey while open, then bad first key
    do_reset(); unlock();
    wr(AK, KA);
    rd(AC, v); chk("R4 rekey locks", {31'd0, v[31]}, 32'd1);
    unlock();
    rd(AC, v); chk("R4 sticky after rekey", {31'd0, v[31]}, 32'd1);
    do_reset();
    wr(AK, 32'hDEAD_BEEF); unlock();
    rd(AC, v); chk("R4 sticky after bad key", {31'd0, v[31]}, 32'd1);

    // R5 relock keeps fields
    do_reset(); unlock();
    w = cw(1'b1, 0, 0, 0, 0, 7'h55, 1'b1, 5'h0A, 0);
    wr(AC, w);
    rd(AC, v); chk("R5 fields written", v, w);
    wr(AC, cw(1'b0, 1, 1, 1, 0, 7'h2A, 1'b0, 5'h15, 1));
    rd(AC, v); chk("R5 relock keeps fields", v, w | 32'h8000_0000);
    wr(AC, 32'h0);
    unlock();
    rd(AC, v); chk("R5 reopen", v, w);
    wr(AC, 32'h0);

    // R6 sweep of all sectors, alternating bank, plus bank and whole-array kinds
    for (int s = 0; s < 128; s++) launch_ok(1'b1, 1'b0, 1'b0, 7'(s), s[0], 2'd0);
    launch_ok(1'b0, 1'b1, 1'b0, 7'd3, 1'b1, 2'd1);
    launch_ok(1'b0, 1'b0, 1'b1, 7'd9, 1'b0, 2'd2);

    // R7 software zero does not clear start; error does
    wr(AC, cw(0, 0, 1, 0, 1, 7'd0, 0, 5'd0, 0));
    @(negedge clk);
    chk("R7 launched", {31'd0, op_start_o}, 32'd1);
    wr(AC, cw(0, 0, 1, 0, 0, 7'd0, 0, 5'd0, 0));
    rd(AC, v); chk("R7 zero write ignored", {31'd0, v[4]}, 32'd1);
    op_prot_err_i = 1'b1; @(negedge clk); op_prot_err_i = 1'b0;
    rd(AC, v); chk("R7 cleared by error", {31'd0, v[4]}, 32'd0);
    rd(AS, v); chk("R9 protection flag", v, 32'd2);
    wr(AS, 32'h1F);

    // R8 every request combination
    for (int c = 0; c < 8; c++) begin
      logic bad;
      bad = ($countones(3'(c)) != 1);
      wr(AC, cw(0, c[0], c[1], c[2], 1, 7'd5, 0, 5'd0, 0));
      chk("R8 no pulse at write", {31'd0, op_start_o}, 32'd0);
      @(negedge clk);
      chk("R8 launch iff one request", {31'd0, op_start_o}, {31'd0, !bad});
      if (bad) begin
        rd(AC, v); chk("R8 start dropped", {31'd0, v[4]}, 32'd0);
        rd(AS, v); chk("R8 sequence flag", v, 32'd4);
      end else begin
        op_done_i = 1'b1; @(negedge clk); op_done_i = 1'b0;
      end
      wr(AS, 32'h1F);
    end
    // R8 leftover sequence flag blocks a valid start
    wr(AC, cw(0, 1, 1, 0, 1, 7'd0, 0, 5'd0, 0));
    @(negedge clk);
    wr(AC, cw(0, 1, 0, 0, 1, 7'd0, 0, 5'd0, 0));
    @(negedge clk);
    chk("R8 pending flag blocks", {31'd0, op_start_o}, 32'd0);
    rd(AC, v); chk("R8 start dropped again", {31'd0, v[4]}, 32'd0);
    wr(AS, 32'h1F);

    // R9 raise all flags, then sweep masks while clearing one at a time
    wr(AC, cw(0, 1, 0, 0, 1, 7'd0, 0, 5'd0, 0));
    @(negedge clk);
    op_done_i = 1'b1; @(negedge clk); op_done_i = 1'b0;
    op_prot_err_i = 1'b1; op_strb_err_i = 1'b1; op_inc_err_i = 1'b1;
    @(negedge clk);
    op_prot_err_i = 1'b0; op_strb_err_i = 1'b0; op_inc_err_i = 1'b0;
    wr(AC, cw(0, 0, 0, 0, 1, 7'd0, 0, 5'd0, 0));
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      logic [4:0] rem;
      rem = 5'h1F & ~5'((1 << k) - 1);
      rd(AS, v); chk("R9 remaining flags", v, {27'd0, rem});
      for (int m = 0; m < 32; m++) begin
        wr(AC, cw(0, 0, 0, 0, 0, 7'd0, 0, 5'(m), 0));
        chk("R9 irq", {31'd0, irq_o}, {31'd0, |(rem & 5'(m))});
      end
      wr(AS, 32'(1 << k));
    end
    rd(AS, v); chk("R9 all cleared", v, 32'd0);
    chk("R9 irq idle", {31'd0, irq_o}, 32'd0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule